// File: doc/BRIEF.md
# Sprite Draw Cycle Cost Calculator

This block works out how many machine cycles a sprite-draw instruction costs on a 64-column monochrome display. A draw begins with a start strobe that carries the x coordinate and the number of sprite lines. The preparation cost depends only on those two values. It is computed when the draw is accepted. The scheduler above the block spreads that cost across frame boundaries.

The drawing cost needs the data of each line. The caller streams the lines one per cycle, each beat carrying:
- the sprite byte,
- the two screen bytes that the shifted row lands on,
- a flag marking the line as clipped.

Each row is shifted right by the sub-byte part of x into a two-byte window. Each half of that window is tested for overlap with its screen byte. The result of that test adds to the running cost. After the beat flagged last, the block raises a one-cycle done pulse and presents both totals. Writing the framebuffer is left to other logic.

Top module: `sprite_draw_timer`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0, and both cost outputs are 0.
- R2: Preparation cost equals 136 + lines * (46 + 20 * (x mod 8)), using the values captured on the accepted start.
- R3: Each sprite byte is placed in the high byte of a 16-bit window and shifted right by x mod 8. The high byte of the result is the first byte and overlays scr_lo_i. The low byte is the second byte and overlays scr_hi_i. A byte collides when it shares at least one set bit with its screen byte.
- R4: Drawing cost starts at 24 for every draw.
- R5: Each unclipped line adds 34. It adds a further 16 when x is below 56.
- R6: Each unclipped line adds 1 when its first byte collides and 1 when its second byte collides.
- R7: When x is 56 or more, the second byte never counts as a collision, whatever scr_hi_i holds.
- R8: A line with clipped_i set adds nothing to the drawing cost.
- R9: A start with a line count of 0 needs no line stream. done_o rises in the cycle after the start is accepted, with a preparation cost of 136 and a drawing cost of 24.
- R10: done_o is a single-cycle pulse, and ready_o returns in the cycle after it. While a draw is in progress, ready_o is 0 and a start strobe has no effect on the result.
- R11: Line beats presented while no draw is in progress have no effect on the drawing cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a draw when ready_o is 1 |
| x_i | input | 6 | Sprite x coordinate |
| lines_i | input | 4 | Sprite line count, 0 to 15 |
| ready_o | output | 1 | Block is idle and can accept a start |
| line_valid_i | input | 1 | Line beat present |
| line_last_i | input | 1 | Marks the final line beat of the draw |
| sprite_i | input | 8 | Sprite row byte |
| scr_lo_i | input | 8 | Screen byte under the first shifted byte |
| scr_hi_i | input | 8 | Screen byte under the second shifted byte |
| clipped_i | input | 1 | Line lies outside the screen vertically |
| done_o | output | 1 | One-cycle pulse; both cost outputs are final |
| prep_cost_o | output | 16 | Preparation cost in machine cycles |
| draw_cost_o | output | 16 | Drawing cost in machine cycles |

## Verification
The bench builds the block with its default parameters: a 64-column screen, 8-bit sprite rows, a 4-bit line count and 16-bit costs. With these values every shift amount from 0 to 7 and every line count from 0 to 15 can be reached. The x range also crosses the boundary at 56, where the 16-cycle term and the second-byte collision both drop out. The widest costs, about 2926 for preparation and 804 for drawing, fit well inside the output width, so random draws hit both collision bits, clipped lines and the empty draw without any saturation hiding an error.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int unsigned FETCH_CYC  = 68;
  localparam int unsigned PREP_BASE  = 2 * FETCH_CYC;
  localparam int unsigned PREP_LINE  = 46;
  localparam int unsigned PREP_SHIFT = 20;
  localparam int unsigned DRAW_BASE  = 24;
  localparam int unsigned DRAW_LINE  = 34;
  localparam int unsigned DRAW_NEAR  = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/sdt_prep_calc.sv
module sdt_prep_calc
  import sdt_pkg::*;
#(
  parameter int unsigned SH_W    = 3,
  parameter int unsigned LINES_W = 4,
  parameter int unsigned COST_W  = 16
) (
  input  logic [SH_W-1:0]    sh_i,
  input  logic [LINES_W-1:0] lines_i,
  output logic [COST_W-1:0]  cost_o
);
  logic [COST_W-1:0] per_line;

  always_comb begin
    per_line = COST_W'(PREP_LINE) + COST_W'(PREP_SHIFT) * COST_W'(sh_i);
    cost_o   = COST_W'(PREP_BASE) + COST_W'(lines_i) * per_line;
  end
endmodule

// File: rtl/sdt_shift_collide.sv
module sdt_shift_collide #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned SH_W  = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] sprite_i,
  input  logic [BYTE_W-1:0] scr_lo_i,
  input  logic [BYTE_W-1:0] scr_hi_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              hi_on_i,
  output logic              hit_lo_o,
  output logic              hit_hi_o
);
  logic [2*BYTE_W-1:0] wide;

  always_comb begin
    wide     = {sprite_i, {BYTE_W{1'b0}}} >> sh_i;
    hit_lo_o = |(wide[2*BYTE_W-1:BYTE_W] & scr_lo_i);
    // second byte off-screen past the last full byte column
    hit_hi_o = hi_on_i & (|(wide[BYTE_W-1:0] & scr_hi_i));
  end
endmodule

// File: rtl/sdt_line_cost.sv
module sdt_line_cost
  import sdt_pkg::*;
#(
  parameter int unsigned COST_W = 16
) (
  input  logic              hit_lo_i,
  input  logic              hit_hi_i,
  input  logic              near_i,
  input  logic              clipped_i,
  output logic [COST_W-1:0] cost_o
);
  always_comb begin
    if (clipped_i) begin
      cost_o = '0;
    end else begin
      cost_o = COST_W'(DRAW_LINE) + COST_W'(hit_lo_i) + COST_W'(hit_hi_i)
             + (near_i ? COST_W'(DRAW_NEAR) : '0);
    end
  end
endmodule

// File: rtl/sprite_draw_timer.sv
module sprite_draw_timer
  import sdt_pkg::*;
#(
  parameter int unsigned SCREEN_COLS = 64,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned LINES_W     = 4,
  parameter int unsigned COST_W      = 16,
  localparam int unsigned X_W        = $clog2(SCREEN_COLS),
  localparam int unsigned SH_W       = $clog2(BYTE_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [X_W-1:0]     x_i,
  input  logic [LINES_W-1:0] lines_i,
  output logic               ready_o,
  input  logic               line_valid_i,
  input  logic               line_last_i,
  input  logic [BYTE_W-1:0]  sprite_i,
  input  logic [BYTE_W-1:0]  scr_lo_i,
  input  logic [BYTE_W-1:0]  scr_hi_i,
  input  logic               clipped_i,
  output logic               done_o,
  output logic [COST_W-1:0]  prep_cost_o,
  output logic [COST_W-1:0]  draw_cost_o
);
  localparam logic [X_W-1:0] NEAR_LIM = X_W'(SCREEN_COLS - BYTE_W);

  state_e            state_q;
  logic [X_W-1:0]    x_q;
  logic [COST_W-1:0] prep_q, draw_q;
  logic [COST_W-1:0] prep_w, line_w;
  logic              near_w, hit_lo_w, hit_hi_w;
  logic              accept_w, beat_w;

  assign accept_w = start_i && (state_q == ST_IDLE);
  assign beat_w   = line_valid_i && (state_q == ST_BUSY);
  assign near_w   = x_q < NEAR_LIM;

  sdt_prep_calc #(
    .SH_W(SH_W), .LINES_W(LINES_W), .COST_W(COST_W)
  ) prep_i (
    .sh_i   (x_i[SH_W-1:0]),
    .lines_i(lines_i),
    .cost_o (prep_w)
  );

  sdt_shift_collide #(
    .BYTE_W(BYTE_W)
  ) coll_i (
    .sprite_i(sprite_i),
    .scr_lo_i(scr_lo_i),
    .scr_hi_i(scr_hi_i),
    .sh_i    (x_q[SH_W-1:0]),
    .hi_on_i (near_w),
    .hit_lo_o(hit_lo_w),
    .hit_hi_o(hit_hi_w)
  );

  sdt_line_cost #(
    .COST_W(COST_W)
  ) cost_i (
    .hit_lo_i (hit_lo_w),
    .hit_hi_i (hit_hi_w),
    .near_i   (near_w),
    .clipped_i(clipped_i),
    .cost_o   (line_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      prep_q  <= '0;
      draw_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          x_q     <= x_i;
          prep_q  <= prep_w;
          draw_q  <= COST_W'(DRAW_BASE);
          state_q <= (lines_i == '0) ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: if (beat_w) begin
          draw_q <= draw_q + line_w;
          if (line_last_i) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = state_q == ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign prep_cost_o = prep_q;
  assign draw_cost_o = draw_q;
endmodule

// File: rtl/sdt_checker.sv
module sdt_checker #(
  parameter int unsigned LINES_W = 4,
  parameter int unsigned COST_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [LINES_W-1:0] lines_i,
  input logic               ready_o,
  input logic               done_o,
  input logic [COST_W-1:0]  prep_cost_o,
  input logic [COST_W-1:0]  draw_cost_o
);
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_ready_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  a_r10_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && done_o));
  a_r10_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);
  a_r9_empty_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o && lines_i == '0) |=> done_o);
  a_r4_draw_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> draw_cost_o >= COST_W'(24));
  a_r2_prep_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> prep_cost_o >= COST_W'(136));
endmodule

bind sprite_draw_timer sdt_checker #(.LINES_W(LINES_W), .COST_W(COST_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .lines_i    (lines_i),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .prep_cost_o(prep_cost_o),
  .draw_cost_o(draw_cost_o)
);

// File: tb/sprite_draw_timer_tb_top.sv
module sprite_draw_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  x_i = '0;
  logic [3:0]  lines_i = '0;
  logic        ready_o;
  logic        line_valid_i = 1'b0;
  logic        line_last_i = 1'b0;
  logic [7:0]  sprite_i = '0, scr_lo_i = '0, scr_hi_i = '0;
  logic        clipped_i = 1'b0;
  logic        done_o;
  logic [15:0] prep_cost_o, draw_cost_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] spr[16];
  logic [7:0] slo[16];
  logic [7:0] shi[16];
  logic       clp[16];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sprite_draw_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .x_i(x_i),
    .lines_i(lines_i), .ready_o(ready_o), .line_valid_i(line_valid_i),
    .line_last_i(line_last_i), .sprite_i(sprite_i), .scr_lo_i(scr_lo_i),
    .scr_hi_i(scr_hi_i), .clipped_i(clipped_i), .done_o(done_o),
    .prep_cost_o(prep_cost_o), .draw_cost_o(draw_cost_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_prep(int x, int n);
    return 136 + n * (46 + 20 * (x % 8));
  endfunction

  function automatic int exp_draw(int x, int n);
    int c = 24;
    for (int i = 0; i < n; i++) begin
      logic [15:0] w;
      w = {spr[i], 8'h00} >> (x % 8);
      if (!clp[i]) begin
        c += 34 + ((x < 56) ? 16 : 0);
        if ((w[15:8] & slo[i]) != 0) c += 1;
        if (x < 56 && (w[7:0] & shi[i]) != 0) c += 1;
      end
    end
    return c;
  endfunction

  // runs one draw; disturb drives a start with another x while busy (R10)
  task automatic run_draw(int x, int n, bit disturb, string req);
    @(negedge clk_i);
    start_i = 1'b1; x_i = 6'(x); lines_i = 4'(n);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < n; i++) begin
      line_valid_i = 1'b1; line_last_i = (i == n - 1);
      sprite_i = spr[i]; scr_lo_i = slo[i]; scr_hi_i = shi[i]; clipped_i = clp[i];
      if (disturb) begin start_i = 1'b1; x_i = 6'(x ^ 5); lines_i = 4'(n ^ 3); end
      check({req, " R10 busy"}, int'(ready_o), 0);
      @(negedge clk_i);
      start_i = 1'b0;
    end
    line_valid_i = 1'b0; line_last_i = 1'b0;
    check({req, " R10 done"}, int'(done_o), 1);
    check({req, " R2 prep"}, int'(prep_cost_o), exp_prep(x, n));
    check({req, " draw"}, int'(draw_cost_o), exp_draw(x, n));
    @(negedge clk_i);
    check({req, " R10 pulse"}, int'(done_o), 0);
    check({req, " R10 ready"}, int'(ready_o), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    check("R1 ready", int'(ready_o), 1);
    check("R1 done", int'(done_o), 0);
    check("R1 prep", int'(prep_cost_o), 0);
    check("R1 draw", int'(draw_cost_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 empty draw
    run_draw(13, 0, 0, "R9 empty");
    check("R9 prep", int'(prep_cost_o), 136);
    check("R4 R9 draw", int'(draw_cost_o), 24);

    // R3 R6: full overlap both bytes at shift 3
    for (int i = 0; i < 16; i++) begin
      spr[i] = 8'hFF; slo[i] = 8'h10; shi[i] = 8'h80; clp[i] = 0;
    end
    run_draw(3, 4, 0, "R3 R6 both");
    check("R5 R6 both", int'(draw_cost_o), 24 + 4 * 52);

    // R3: shift 0 leaves second byte empty, no hit
    run_draw(8, 2, 0, "R3 noshift");
    check("R3 noshift", int'(draw_cost_o), 24 + 2 * 51);

    // R7: x>=56, screen fully set under second byte
    for (int i = 0; i < 16; i++) begin
      spr[i] = 8'h0F; slo[i] = 8'h00; shi[i] = 8'hFF;
    end
    run_draw(60, 3, 0, "R7 edge");
    check("R7 edge", int'(draw_cost_o), 24 + 3 * 34);

    // R8: all clipped
    for (int i = 0; i < 16; i++) begin
      spr[i] = 8'hFF; slo[i] = 8'hFF; shi[i] = 8'hFF; clp[i] = 1;
    end
    run_draw(5, 15, 0, "R8 clipped");
    check("R8 clipped", int'(draw_cost_o), 24);

    // R11: beats while idle must not count
    @(negedge clk_i);
    line_valid_i = 1'b1; line_last_i = 1'b1;
    sprite_i = 8'hFF; scr_lo_i = 8'hFF; scr_hi_i = 8'hFF; clipped_i = 1'b0;
    repeat (3) @(negedge clk_i);
    line_valid_i = 1'b0; line_last_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      spr[i] = 8'h00; slo[i] = 8'hFF; shi[i] = 8'hFF; clp[i] = 0;
    end
    run_draw(0, 1, 0, "R11 idle beats");
    check("R11 R5", int'(draw_cost_o), 24 + 50);

    // R10 with disturbing starts, then random draws
    for (int t = 0; t < 60; t++) begin
      int x, n;
      x = int'($urandom_range(63));
      n = int'($urandom_range(15));
      for (int i = 0; i < 16; i++) begin
        spr[i] = 8'($urandom); slo[i] = 8'($urandom); shi[i] = 8'($urandom);
        clp[i] = ($urandom_range(7) == 0);
      end
      run_draw(x, n, (t % 4 == 0), "R2 R3 R5 R6 R7 R8 rand");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule